// File: doc/BRIEF.md
# Flash Operation Status Byte Generator

This block decides which byte a host sees when it reads a flash device while an internal program or erase is in flight. Once an operation is launched, every host read is answered with a status byte rather than plain array contents. Bit 7 carries a polling flag: the inverted top bit of the byte being programmed, or zero during an erase. Bit 6 carries a flag that changes on every read. Bits 5 down to 0 pass the current array byte through. When the operation is over, reads return the array byte unchanged.

The length of each operation comes from an internal cycle counter with separate program and erase durations set by parameters. The surrounding engine supplies the start pulse, the kind of operation, the byte to be programmed and the array byte at the current read address. A host that polls bit 7 at the target address, or watches bit 6 for changes, can tell when the operation has finished.

If a program tries to raise a bit that is already cleared in the target byte, the block treats the program as failed. In that case the changing flag freezes for the rest of the operation.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, `hostData` is 8'h00 and `busy` is 0.
- R2: An `opStart` pulse while idle, with `opKind` 2'b00 (program), 2'b01 (chip erase) or 2'b10 (page erase), sets `busy` at the next clock edge. `busy` then stays high for exactly PROG_CYCLES clock cycles for a program, or ERASE_CYCLES cycles for either erase.
- R3: An `opStart` pulse is ignored if it arrives while `busy` is high, or if it carries `opKind` 2'b11. Neither case changes when the running operation ends.
- R4: During a program, bit 7 of each read result is the inverse of bit 7 of `progData` as captured at start.
- R5: During either erase, bit 7 of each read result is 0. After the erase, a read returns the array byte (8'hFF for an erased location).
- R6: During an operation, bit 6 of the read result is 1 on the first read after start and inverts on each later read, at any address. The flag is cleared at every start.
- R7: During an operation, bits 5:0 of the read result equal bits 5:0 of `arrayData` in the strobe cycle.
- R8: A read while idle returns `arrayData` unchanged, sampled in the strobe cycle. `hostData` holds its value between read strobes.
- R9: If, at a program start, `progData` has a 1 in any bit where `arrayData` has a 0, then bit 6 reads 0 on every read of that operation.
- R10: `progData` is captured at start. Changing it while busy does not change bit 7 of the read results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opStart | input | 1 | One-cycle pulse that launches an operation |
| opKind | input | 2 | 00 program, 01 chip erase, 10 page erase, 11 reserved |
| progData | input | 8 | Byte to program, captured at start |
| rdStrobe | input | 1 | One-cycle host read pulse |
| arrayData | input | 8 | Array byte at the current address (the target byte at a program start) |
| hostData | output | 8 | Byte returned to the host, updated one edge after each read strobe |
| busy | output | 1 | High while an operation runs |

## Verification
The bench reads at each of these states and compares the returned byte with an independently computed expectation, so a wrong internal state shows up in `hostData` on the first read after it. A toggle flag that is not cleared at start shows as bit 6 = 0 on the first busy read. A polling bit captured with the wrong kind or at the wrong time shows as the wrong bit 7 on any busy read. A counter that is reloaded by a second start, or that is off by one, shows in `busy`, which is counted cycle by cycle. A missed fault detection shows as bit 6 alternating when it should stay at 0.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;

  typedef enum logic [1:0] {
    KIND_PROGRAM    = 2'b00,
    KIND_CHIP_ERASE = 2'b01,
    KIND_PAGE_ERASE = 2'b10,
    KIND_RESERVED   = 2'b11
  } opKind_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic loadOp;      // operation accepted this cycle
    logic isProgram;   // accepted operation is a program
    logic readStatus;  // host read while busy
    logic readArray;   // host read while idle
    logic flipToggle;  // invert the toggle flag on this read
  } stsStrobes_t;

endpackage

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import flash_status_pkg::*;
#(
  parameter int unsigned PROG_CYCLES  = 20,
  parameter int unsigned ERASE_CYCLES = 60,
  parameter int unsigned DATA_W       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opStart,
  input  logic [1:0]        opKind,
  input  logic [DATA_W-1:0] progData,
  input  logic [DATA_W-1:0] arrayData,
  input  logic              rdStrobe,
  output logic              busy,
  output stsStrobes_t       strobes
);

  localparam int unsigned MAX_CYCLES = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int unsigned CNT_W      = $clog2(MAX_CYCLES + 1);
  localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES - 1);

  opKind_t          kind;
  logic             kindValid;
  logic             accept;
  logic             raiseAttempt;
  logic             faultQ;
  logic [CNT_W-1:0] cntQ;

  assign kind         = opKind_t'(opKind);
  assign kindValid    = (kind != KIND_RESERVED);
  assign accept       = opStart && !busy && kindValid;
  assign raiseAttempt = |(progData & ~arrayData);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      cntQ   <= '0;
      faultQ <= 1'b0;
    end else if (accept) begin
      busy   <= 1'b1;
      cntQ   <= (kind == KIND_PROGRAM) ? PROG_LOAD : ERASE_LOAD;
      faultQ <= (kind == KIND_PROGRAM) && raiseAttempt;
    end else if (busy) begin
      if (cntQ == '0) begin
        busy   <= 1'b0;
        faultQ <= 1'b0;
      end else begin
        cntQ <= cntQ - 1'b1;
      end
    end
  end

  always_comb begin
    strobes            = '0;
    strobes.loadOp     = accept;
    strobes.isProgram  = (kind == KIND_PROGRAM);
    strobes.readStatus = rdStrobe && busy;
    strobes.readArray  = rdStrobe && !busy;
    strobes.flipToggle = rdStrobe && busy && !faultQ;
  end

  // R2: an accepted start always leaves the block busy
  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadOp |=> busy);

  // R3: once running, the counter only counts down; a second start does not reload it
  a_r3_no_reload: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cntQ != '0) |=> (busy && cntQ == $past(cntQ) - 1'b1));

  // R3: reserved kind never starts anything
  a_r3_reserved_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && opStart && opKind == 2'b11) |=> !busy);

  // R9: a failed program never flips the toggle
  a_r9_fault_freezes: assert property (@(posedge clk) disable iff (!rstN)
    (busy && faultQ) |-> !strobes.flipToggle);

endmodule

// File: rtl/flash_status_data.sv
module flash_status_data
  import flash_status_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  stsStrobes_t       strobes,
  input  logic [DATA_W-1:0] progData,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] hostData
);

  localparam int unsigned POLL_BIT   = DATA_W - 1;
  localparam int unsigned TOGGLE_BIT = DATA_W - 2;
  localparam int unsigned PASS_W     = DATA_W - 2;

  logic              pollQ;
  logic              toggleQ;
  logic              toggleNext;
  logic [DATA_W-1:0] hostQ;
  logic [DATA_W-1:0] statusByte;

  assign toggleNext = strobes.flipToggle ? ~toggleQ : toggleQ;

  always_comb begin
    statusByte             = '0;
    statusByte[POLL_BIT]   = pollQ;
    statusByte[TOGGLE_BIT] = toggleNext;
    statusByte[PASS_W-1:0] = arrayData[PASS_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pollQ   <= 1'b0;
      toggleQ <= 1'b0;
    end else if (strobes.loadOp) begin
      pollQ   <= strobes.isProgram ? ~progData[POLL_BIT] : 1'b0;
      toggleQ <= 1'b0;
    end else begin
      toggleQ <= toggleNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostQ <= '0;
    end else if (strobes.readStatus) begin
      hostQ <= statusByte;
    end else if (strobes.readArray) begin
      hostQ <= arrayData;
    end
  end

  assign hostData = hostQ;

  // R6: each start clears the toggle flag
  a_r6_toggle_cleared: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadOp |=> (toggleQ == 1'b0));

  // R6: a flipping read inverts the flag
  a_r6_toggle_flips: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flipToggle |=> (toggleQ != $past(toggleQ)));

  // R8: an idle read returns the array byte
  a_r8_idle_read: assert property (@(posedge clk) disable iff (!rstN)
    strobes.readArray |=> (hostQ == $past(arrayData)));

  // R8: no strobe, no change
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.readArray || strobes.readStatus) |=> $stable(hostQ));

  // R4 R5: busy reads carry the captured polling bit
  a_r4_poll_bit: assert property (@(posedge clk) disable iff (!rstN)
    strobes.readStatus |=> (hostQ[POLL_BIT] == $past(pollQ)));

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_status_pkg::*;
#(
  parameter int unsigned PROG_CYCLES  = 20,
  parameter int unsigned ERASE_CYCLES = 60
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       opStart,
  input  logic [1:0] opKind,
  input  logic [7:0] progData,
  input  logic       rdStrobe,
  input  logic [7:0] arrayData,
  output logic [7:0] hostData,
  output logic       busy
);

  localparam int unsigned DATA_W = 8;

  stsStrobes_t strobes;

  flash_status_ctrl #(
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES),
    .DATA_W      (DATA_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .opStart  (opStart),
    .opKind   (opKind),
    .progData (progData),
    .arrayData(arrayData),
    .rdStrobe (rdStrobe),
    .busy     (busy),
    .strobes  (strobes)
  );

  flash_status_data #(
    .DATA_W(DATA_W)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .progData (progData),
    .arrayData(arrayData),
    .hostData (hostData)
  );

endmodule

// File: tb/flash_status_gen_tb.sv
module flash_status_gen_tb;

  localparam int PROG  = 12;
  localparam int ERASE = 30;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opStart = 1'b0;
  logic [1:0] opKind = 2'b00;
  logic [7:0] progData = 8'h00;
  logic       rdStrobe = 1'b0;
  logic [7:0] arrayData = 8'hFF;
  logic [7:0] hostData;
  logic       busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] expQ[$];
  string      tagQ[$];
  logic       strobeSeen = 1'b0;

  always #5 clk = ~clk;

  flash_status_gen #(.PROG_CYCLES(PROG), .ERASE_CYCLES(ERASE)) u_dut (
    .clk(clk), .rstN(rstN), .opStart(opStart), .opKind(opKind),
    .progData(progData), .rdStrobe(rdStrobe), .arrayData(arrayData),
    .hostData(hostData), .busy(busy)
  );

  task automatic checkVal(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares each read result one edge after its strobe
  always @(posedge clk) strobeSeen <= rdStrobe;

  always @(negedge clk) begin
    if (strobeSeen) begin
      if (expQ.size() == 0) begin
        checkVal("scoreboard underflow", 1, 0);
      end else begin
        checkVal(tagQ.pop_front(), int'(hostData), int'(expQ.pop_front()));
      end
    end
  end

  // driver: one read strobe, with its expected byte
  task automatic readOnce(input logic [7:0] exp, input string tag);
    @(negedge clk);
    rdStrobe = 1'b1;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic startOp(input logic [1:0] kind, input logic [7:0] pd);
    @(negedge clk);
    opKind   = kind;
    progData = pd;
    opStart  = 1'b1;
    @(negedge clk);
    opStart  = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  function automatic logic [7:0] stsByte(input logic poll, input logic tog, input logic [7:0] arr);
    return {poll, tog, arr[5:0]};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL R2 watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stimulus
    int n;
    repeat (3) @(negedge clk);
    checkVal("R1 reset hostData", int'(hostData), 0);
    checkVal("R1 reset busy", int'(busy), 0);
    rstN = 1'b1;
    @(negedge clk);

    // program, no fault: array all ones at start
    arrayData = 8'hFF;
    startOp(2'b00, 8'h5A);
    checkVal("R2 busy after program start", int'(busy), 1);
    arrayData = 8'hE5;
    readOnce(stsByte(1'b1, 1'b1, 8'hE5), "R4 R6 R7 read1");
    readOnce(stsByte(1'b1, 1'b0, 8'hE5), "R6 read2");
    arrayData = 8'h2B;
    readOnce(stsByte(1'b1, 1'b1, 8'h2B), "R6 R7 read3");
    progData = 8'hFF;
    readOnce(stsByte(1'b1, 1'b0, 8'h2B), "R10 progData change ignored");
    waitIdle();
    arrayData = 8'h3C;
    readOnce(8'h3C, "R8 idle read");
    arrayData = 8'h99;
    repeat (3) @(negedge clk);
    checkVal("R8 hold between strobes", int'(hostData), 8'h3C);

    // program with top bit set: polling bit 0
    arrayData = 8'hFF;
    startOp(2'b00, 8'h80);
    readOnce(stsByte(1'b0, 1'b1, 8'hFF), "R4 inverted bit7 one");
    waitIdle();

    // toggle cleared at the next start (previous op ended with flag 1)
    arrayData = 8'hFF;
    startOp(2'b00, 8'h11);
    readOnce(stsByte(1'b1, 1'b1, 8'hFF), "R6 flag cleared at start");
    waitIdle();

    // program durations
    arrayData = 8'hFF;
    startOp(2'b00, 8'h00);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    checkVal("R2 program duration", n, PROG);

    // chip erase: polling 0, then array reads 1
    arrayData = 8'h7F;
    startOp(2'b01, 8'h00);
    readOnce(stsByte(1'b0, 1'b1, 8'h7F), "R5 chip erase read1");
    readOnce(stsByte(1'b0, 1'b0, 8'h7F), "R5 chip erase read2");
    waitIdle();
    arrayData = 8'hFF;
    readOnce(8'hFF, "R5 after erase");

    // page erase duration
    startOp(2'b10, 8'hAA);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    checkVal("R2 page erase duration", n, ERASE);

    // chip erase duration
    startOp(2'b01, 8'h00);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    checkVal("R2 chip erase duration", n, ERASE);

    // reserved kind ignored
    startOp(2'b11, 8'h00);
    checkVal("R3 reserved kind ignored", int'(busy), 0);
    readOnce(8'hFF, "R3 reserved kind read is array");

    // restart during busy ignored
    startOp(2'b00, 8'h00);
    n = 0;
    while (busy) begin
      n++;
      if (n == 4) begin opKind = 2'b01; opStart = 1'b1; end
      else opStart = 1'b0;
      @(negedge clk);
    end
    opStart = 1'b0;
    checkVal("R3 restart while busy ignored", n, PROG);

    // failed program: raise a cleared bit, toggle frozen
    arrayData = 8'h0F;
    startOp(2'b00, 8'hF0);
    readOnce(stsByte(1'b0, 1'b0, 8'h0F), "R9 fault read1");
    readOnce(stsByte(1'b0, 1'b0, 8'h0F), "R9 fault read2");
    readOnce(stsByte(1'b0, 1'b0, 8'h0F), "R9 fault read3");
    waitIdle();
    readOnce(8'h0F, "R8 read after failed program");

    repeat (3) @(negedge clk);
    checkVal("scoreboard drained", expQ.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule